// File: doc/BRIEF.md
# Speculative Load Check Table

This block lets software hoist loads above stores that might alias them and above the branches that guard them, and then confirm later whether each hoisted value is still usable. A load issued in advanced form writes its destination register number, start address and access size into a small associative table. Every store presented afterwards compares its own byte range with each table entry and drops the entries it touches. A check request names a register and a recovery address. The answer, one cycle later, either lets execution go on or tells it to jump to that recovery address.

Control-speculative loads never trap. Each architectural register instead carries a deferred-fault bit. A faulting load sets that bit and a clean load clears it. A speculation-type check on a register whose bit is set answers with a redirect to its recovery address. The memory system itself is outside this block. The block sees only the record, snoop and check traffic on its ports.

Top module: `spec_check_table`

## Requirements
- R1: After reset no table entry is valid, every deferred-fault bit is clear and `rsp_valid` is 0.
- R2: A load with `ld_valid`=1, `ld_adv`=1 and `ld_fault`=0 records (register, address, size). A later advanced check (`chk_spec`=0) on that register answers no redirect and leaves the entry in place, so a repeated check also answers no redirect.
- R3: An advanced check on a register with no valid entry answers redirect.
- R4: An access covers bytes `addr` to `addr + 2^size - 1`, where size code 0, 1, 2 and 3 means 1, 2, 4 and 8 bytes. Addresses do not wrap past the top of the 64-bit space. A store (`st_valid`=1) removes every valid entry whose byte range overlaps its own and keeps every entry that does not overlap, including entries that only touch it on an adjacent byte.
- R5: A new advanced load to a register removes any older entry for that register. Only the newest address then counts for that register.
- R6: The table has 16 slots, filled round-robin. After 16 records, the 17th record overwrites the slot written first.
- R7: Ordering within one cycle: the store is snooped first and the check is answered next. The load is recorded last, so a check in the same cycle as a load sees the state from before that load, and a store in the same cycle as a load does not remove that load.
- R8: A response appears exactly one cycle after each check request (`rsp_valid`=1 for one cycle per request). `rsp_addr` equals the request's `chk_target` when `rsp_redirect`=1, and is 0 otherwise.
- R9: Every load with `ld_valid`=1 sets its register's deferred-fault bit to `ld_fault`. A speculation check (`chk_spec`=1) answers redirect exactly when that bit is set. A faulting advanced load records no entry, but it still removes older entries for its register.
- R10: A load with `ld_adv`=0 leaves the table untouched. A speculation check ignores the table, and an advanced check ignores the deferred-fault bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A load completes this cycle |
| ld_adv | input | 1 | The load is advanced and is to be recorded in the table |
| ld_reg | input | 7 | Destination register of the load |
| ld_addr | input | 64 | Start byte address of the load |
| ld_size | input | 2 | Log2 of the load's byte count |
| ld_fault | input | 1 | The load hit an exception that is deferred |
| st_valid | input | 1 | A store is snooped this cycle |
| st_addr | input | 64 | Start byte address of the store |
| st_size | input | 2 | Log2 of the store's byte count |
| chk_valid | input | 1 | Check request |
| chk_spec | input | 1 | 0: advanced check against the table; 1: deferred-fault check |
| chk_reg | input | 7 | Register named by the check |
| chk_target | input | 64 | Recovery address for the check |
| rsp_valid | output | 1 | Check response valid |
| rsp_redirect | output | 1 | Go to the recovery address |
| rsp_addr | output | 64 | Recovery address when redirecting, else 0 |

## Verification
The bench targets the boundaries of the range comparison. A store on the byte right after a load must spare the entry, and a store straddling the load's first byte must kill it. An off-by-one comparator would kill or keep the wrong one, and a comparator that wraps at the top of the address space would falsely kill a load that sits at the very top. The same-cycle orderings of load, store and check are driven directly, because a design that applies the load before the check, or the store after the load, would answer "ok" where a redirect is due, or the other way round. The bench also overflows the table and re-records the same register at a new address, which catches a pointer that does not wrap and stale duplicate entries that would keep answering "ok".

// File: rtl/spec_chk_pkg.sv
package spec_chk_pkg;

    localparam int SLC_ADDR_W = 64;
    localparam int SLC_SIZE_W = 2;

    typedef logic [SLC_ADDR_W-1:0] addr_t;
    typedef logic [SLC_SIZE_W-1:0] lsize_t;

    typedef struct packed {
        logic  valid;
        logic  redirect;
        addr_t addr;
    } rsp_t;

    // Byte ranges [a, a+2^as) and [b, b+2^bs), computed without wrap-around.
    function automatic logic ranges_overlap(input addr_t a, input lsize_t as_,
                                            input addr_t b, input lsize_t bs_);
        logic [SLC_ADDR_W:0] a_end;
        logic [SLC_ADDR_W:0] b_end;
        a_end = {1'b0, a} + ((SLC_ADDR_W+1)'(1) << as_);
        b_end = {1'b0, b} + ((SLC_ADDR_W+1)'(1) << bs_);
        return ({1'b0, a} < b_end) && ({1'b0, b} < a_end);
    endfunction

endpackage

// File: rtl/spec_chk_table.sv
module spec_chk_table
    import spec_chk_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int REG_W   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rm_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_reg,
    input  addr_t            wr_addr,
    input  lsize_t           wr_size,
    input  logic             st_en,
    input  addr_t            st_addr,
    input  lsize_t           st_size,
    input  logic [REG_W-1:0] q_reg,
    output logic             q_hit
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    typedef struct {
        logic [ENTRIES-1:0] vld;
        logic [IDX_W-1:0]   ptr;
        logic [REG_W-1:0]   tag  [ENTRIES];
        addr_t              addr [ENTRIES];
        lsize_t             size [ENTRIES];
    } tab_t;

    tab_t tab_q, tab_d;

    logic [ENTRIES-1:0] st_kill;
    logic [ENTRIES-1:0] q_match;
    logic [ENTRIES-1:0] wr_match;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign st_kill[i]  = st_en && tab_q.vld[i] &&
                             ranges_overlap(tab_q.addr[i], tab_q.size[i], st_addr, st_size);
        assign q_match[i]  = tab_q.tag[i] == q_reg;
        assign wr_match[i] = tab_q.tag[i] == wr_reg;
    end

    logic [ENTRIES-1:0] vld_snooped;
    assign vld_snooped = tab_q.vld & ~st_kill;
    assign q_hit       = |(vld_snooped & q_match);

    always_comb begin
        tab_d     = tab_q;
        tab_d.vld = vld_snooped & ~({ENTRIES{rm_en}} & wr_match);
        if (wr_en) begin
            tab_d.vld[tab_q.ptr]  = 1'b1;
            tab_d.tag[tab_q.ptr]  = wr_reg;
            tab_d.addr[tab_q.ptr] = wr_addr;
            tab_d.size[tab_q.ptr] = wr_size;
            tab_d.ptr = (tab_q.ptr == LAST) ? '0 : tab_q.ptr + IDX_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tab_q.vld <= '0;
            tab_q.ptr <= '0;
        end else begin
            tab_q <= tab_d;
        end
    end

endmodule

// File: rtl/spec_chk_fault.sv
module spec_chk_fault #(
    parameter int REG_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [REG_W-1:0] set_reg,
    input  logic             set_val,
    input  logic [REG_W-1:0] q_reg,
    output logic             q_bit
);
    localparam int NREGS = 1 << REG_W;

    logic [NREGS-1:0] bits_q, bits_d;

    assign q_bit = bits_q[q_reg];

    always_comb begin
        bits_d = bits_q;
        if (set_en) bits_d[set_reg] = set_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

endmodule

// File: rtl/spec_check_table.sv
module spec_check_table
    import spec_chk_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int REG_W   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_valid,
    input  logic             ld_adv,
    input  logic [REG_W-1:0] ld_reg,
    input  logic [63:0]      ld_addr,
    input  logic [1:0]       ld_size,
    input  logic             ld_fault,
    input  logic             st_valid,
    input  logic [63:0]      st_addr,
    input  logic [1:0]       st_size,
    input  logic             chk_valid,
    input  logic             chk_spec,
    input  logic [REG_W-1:0] chk_reg,
    input  logic [63:0]      chk_target,
    output logic             rsp_valid,
    output logic             rsp_redirect,
    output logic [63:0]      rsp_addr
);
    logic tab_hit;
    logic fault_bit;
    rsp_t rsp_q, rsp_d;

    spec_chk_table #(.ENTRIES(ENTRIES), .REG_W(REG_W)) u_tab (
        .clk     (clk),
        .rst_n   (rst_n),
        .rm_en   (ld_valid && ld_adv),
        .wr_en   (ld_valid && ld_adv && !ld_fault),
        .wr_reg  (ld_reg),
        .wr_addr (ld_addr),
        .wr_size (ld_size),
        .st_en   (st_valid),
        .st_addr (st_addr),
        .st_size (st_size),
        .q_reg   (chk_reg),
        .q_hit   (tab_hit)
    );

    spec_chk_fault #(.REG_W(REG_W)) u_flt (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (ld_valid),
        .set_reg (ld_reg),
        .set_val (ld_fault),
        .q_reg   (chk_reg),
        .q_bit   (fault_bit)
    );

    always_comb begin
        rsp_d          = '0;
        rsp_d.valid    = chk_valid;
        rsp_d.redirect = chk_valid && (chk_spec ? fault_bit : !tab_hit);
        rsp_d.addr     = rsp_d.redirect ? chk_target : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid    = rsp_q.valid;
    assign rsp_redirect = rsp_q.redirect;
    assign rsp_addr     = rsp_q.addr;

endmodule

module spec_check_table_chk #(
    parameter int REG_W = 7
) (
    input logic        clk,
    input logic        rst_n,
    input logic        chk_valid,
    input logic [63:0] chk_target,
    input logic        rsp_valid,
    input logic        rsp_redirect,
    input logic [63:0] rsp_addr
);
    assert_rsp_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> rsp_valid);

    assert_no_spurious_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !rsp_valid);

    assert_redirect_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> (!rsp_redirect || rsp_addr == $past(chk_target)));

    assert_ok_addr_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_redirect) |-> rsp_addr == 64'd0);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_redirect && rsp_addr == 64'd0));
endmodule

bind spec_check_table spec_check_table_chk #(.REG_W(REG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .chk_valid    (chk_valid),
    .chk_target   (chk_target),
    .rsp_valid    (rsp_valid),
    .rsp_redirect (rsp_redirect),
    .rsp_addr     (rsp_addr)
);

// File: tb/spec_check_table_tb.sv
`timescale 1ns/1ps
module spec_check_table_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 0, ld_adv = 0, ld_fault = 0;
    logic [6:0]  ld_reg = '0;
    logic [63:0] ld_addr = '0;
    logic [1:0]  ld_size = '0;
    logic        st_valid = 0;
    logic [63:0] st_addr = '0;
    logic [1:0]  st_size = '0;
    logic        chk_valid = 0, chk_spec = 0;
    logic [6:0]  chk_reg = '0;
    logic [63:0] chk_target = '0;
    logic        rsp_valid, rsp_redirect;
    logic [63:0] rsp_addr;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    spec_check_table u_dut (.*);

    // Behavioural reference
    bit              m_v   [16];
    int              m_reg [16];
    longint unsigned m_lo  [16];
    int              m_sz  [16];
    int              m_ptr;
    bit              m_flt [128];

    function automatic bit touches(longint unsigned a, int as_, longint unsigned b, int bs_);
        bit [64:0] ae, be;
        ae = {1'b0, a} + (65'd1 << as_);
        be = {1'b0, b} + (65'd1 << bs_);
        return ({1'b0, a} < be) && ({1'b0, b} < ae);
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 16; i++) m_v[i] = 0;
        for (int r = 0; r < 128; r++) m_flt[r] = 0;
        m_ptr = 0;
    endtask

    task automatic idle();
        ld_valid = 0; ld_adv = 0; ld_fault = 0;
        st_valid = 0; chk_valid = 0; chk_spec = 0;
    endtask

    task automatic expect1(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One clock: reference steps with the current inputs, outputs compared after the edge.
    task automatic tick(string tag);
        bit e_v, e_r;
        bit hit;
        e_v = chk_valid;
        e_r = 0;
        if (st_valid)
            for (int i = 0; i < 16; i++)
                if (m_v[i] && touches(m_lo[i], m_sz[i], st_addr, int'(st_size))) m_v[i] = 0;
        if (chk_valid) begin
            if (chk_spec) e_r = m_flt[chk_reg];
            else begin
                hit = 0;
                for (int i = 0; i < 16; i++)
                    if (m_v[i] && m_reg[i] == int'(chk_reg)) hit = 1;
                e_r = !hit;
            end
        end
        if (ld_valid) begin
            m_flt[ld_reg] = ld_fault;
            if (ld_adv) begin
                for (int i = 0; i < 16; i++)
                    if (m_reg[i] == int'(ld_reg)) m_v[i] = 0;
                if (!ld_fault) begin
                    m_v[m_ptr] = 1; m_reg[m_ptr] = int'(ld_reg);
                    m_lo[m_ptr] = ld_addr; m_sz[m_ptr] = int'(ld_size);
                    m_ptr = (m_ptr + 1) % 16;
                end
            end
        end
        @(posedge clk); #1;
        expect1(tag, "rsp_valid", 64'(rsp_valid), 64'(e_v));
        expect1(tag, "rsp_redirect", 64'(rsp_redirect), 64'(e_r));
        expect1(tag, "rsp_addr", rsp_addr, e_r ? chk_target : 64'd0);
        idle();
    endtask

    task automatic do_reset();
        rst_n = 0; idle(); model_clear();
        for (int i = 0; i < 16; i++) m_reg[i] = -1;
        repeat (2) @(posedge clk);
        #1;
        expect1("R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
        rst_n = 1;
    endtask

    task automatic adv_load(int r, longint unsigned a, int s, bit f);
        ld_valid = 1; ld_adv = 1; ld_reg = 7'(r); ld_addr = a; ld_size = 2'(s); ld_fault = f;
    endtask

    task automatic plain_load(int r, bit f);
        ld_valid = 1; ld_adv = 0; ld_reg = 7'(r); ld_addr = 64'h100; ld_size = 0; ld_fault = f;
    endtask

    task automatic store(longint unsigned a, int s);
        st_valid = 1; st_addr = a; st_size = 2'(s);
    endtask

    task automatic check(int r, bit spec);
        chk_valid = 1; chk_spec = spec; chk_reg = 7'(r);
        chk_target = 64'hC0DE_0000 + 64'(r) + (spec ? 64'h1000 : 64'h0);
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1;
        do_reset();
        // R1 / R3: empty table and clear fault bits
        check(5, 0); tick("R1_R3 empty table redirects");
        check(5, 1); tick("R1 fault bit clear");
        // R2
        adv_load(10, 64'h1000, 3, 0); tick("R2 record");
        check(10, 0); tick("R2 check ok");
        check(10, 0); tick("R2 entry kept");
        // R4 adjacent and straddling stores
        store(64'h1008, 0); tick("R4 adjacent store");
        check(10, 0); tick("R4 adjacent keeps entry");
        store(64'h0FFF, 1); tick("R4 straddling store");
        check(10, 0); tick("R4 overlap kills entry");
        // R5 re-record
        adv_load(11, 64'h2000, 2, 0); tick("R5 first");
        adv_load(11, 64'h3000, 2, 0); tick("R5 second");
        store(64'h2000, 3); tick("R5 old address store");
        check(11, 0); tick("R5 old address ignored");
        store(64'h3002, 0); tick("R5 new address store");
        check(11, 0); tick("R5 new address kills");
        // R7 same-cycle orderings
        adv_load(12, 64'h4000, 3, 0); tick("R7 setup");
        store(64'h4004, 0); check(12, 0); tick("R7 store before check");
        adv_load(13, 64'h5000, 3, 0); check(13, 0); tick("R7 check before load");
        check(13, 0); tick("R7 load visible next cycle");
        adv_load(14, 64'h6000, 3, 0); store(64'h6000, 3); tick("R7 load after store");
        check(14, 0); tick("R7 same-cycle store spares load");
        // R4 top of address space, no wrap
        adv_load(50, 64'hFFFF_FFFF_FFFF_FFFC, 2, 0); tick("R4 top record");
        store(64'h0, 3); tick("R4 low store");
        check(50, 0); tick("R4 no wrap-around");
        store(64'hFFFF_FFFF_FFFF_FFFF, 0); tick("R4 top byte store");
        check(50, 0); tick("R4 top byte kills");
        // R9 deferred faults
        plain_load(40, 1); tick("R9 faulting load");
        check(40, 1); tick("R9 spec check redirects");
        check(40, 0); tick("R10 adv check ignores fault bit");
        plain_load(40, 0); tick("R9 clean load");
        check(40, 1); tick("R9 bit cleared");
        adv_load(41, 64'h7000, 3, 0); tick("R9 setup");
        adv_load(41, 64'h7100, 3, 1); tick("R9 faulting advanced load");
        check(41, 0); tick("R9 faulting adv load not recorded");
        check(41, 1); tick("R9 faulting adv sets bit");
        // R10 plain load leaves table alone
        adv_load(60, 64'h8000, 3, 0); tick("R10 setup");
        plain_load(60, 0); tick("R10 plain load");
        check(60, 0); tick("R10 entry kept");
        check(61, 1); tick("R10 spec check ignores table");
        // R6 round-robin
        do_reset();
        for (int k = 0; k < 16; k++) begin
            adv_load(20 + k, 64'h10000 + 64'(k) * 64'h100, 3, 0); tick("R6 fill");
        end
        check(20, 0); tick("R6 full table ok");
        adv_load(36, 64'h20000, 3, 0); tick("R6 seventeenth");
        check(20, 0); tick("R6 oldest evicted");
        check(21, 0); tick("R6 next kept");
        check(36, 0); tick("R6 newest present");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule